// File: doc/BRIEF.md
# I2C Target Controller with Access Status Flags

This block answers on a two-wire serial bus as a target with a seven-bit own address that is set on an input port. It passes SCL and SDA through two-flop synchronisers and finds START, repeated START and STOP conditions. It reads the address byte and the R/W bit, and it acknowledges only its own address. When the controller writes, each byte that arrives is moved into a receive holding register and acknowledged. When the controller reads, bytes are sent MSB first from a transmit holding register. The block drives SDA only through an open-drain enable and never drives it high.

A host works the block through single-cycle strobes: one writes the transmit holding register, one reads the receive holding register, and one reads status. The status flags are access active, direction, end of access, receive ready, transmit ready, controller NACK and overrun. They let the host follow each transfer without polling the bus.

States and transitions: `S_IDLE` is the state after reset or STOP. A START in any state leads to `S_ADDR`, where eight bits are shifted in. At the falling SCL edge after the eighth bit, a match leads to `S_ADDR_ACK` and a mismatch to `S_SKIP`. After the ninth clock, `S_ADDR_ACK` goes to `S_WR_DATA` for a write or to `S_RD_DATA` for a read. `S_WR_DATA` goes to `S_WR_ACK` after eight bits, and `S_WR_ACK` returns to `S_WR_DATA` after the ninth clock. `S_RD_DATA` goes to `S_RD_ACK` after eight bits. In `S_RD_ACK`, an ACK returns to `S_RD_DATA` with the next byte, and a NACK leads to `S_SKIP`. `S_SKIP` holds SDA released until the next START. A STOP returns any state to `S_IDLE`.

Top module: `i2c_target_ctrl`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. SDA is sampled on rising SCL edges. `sda_oe` (1 = pull SDA low) changes only while SCL is low, except that it is released on a START or STOP.
- R2: After a START or repeated START, the first byte is the address: bits 7..1 are the address and bit 0 is R/W, with 1 meaning the controller reads. When bits 7..1 equal `own_addr`, the block pulls SDA low for the ninth clock, sets `st_active`, and sets `st_read` equal to the R/W bit.
- R3: A non-matching address is not acknowledged. SDA stays released until the next START, and no data is stored. If an access was active, `st_active` clears and `st_end` sets.
- R4: A STOP clears `st_active` and sets `st_end` if an access was active.
- R5: In a write, every data byte is acknowledged, moved to `rx_data`, and sets `st_rx_ready`. A `host_rd_rx` strobe clears `st_rx_ready`.
- R6: A byte that arrives while `st_rx_ready` is still set overwrites `rx_data` and sets the sticky flag `st_overrun`.
- R7: In a read, the transmit byte is loaded into the shifter at the falling SCL edge that ends each ACK slot, and `st_tx_ready` clears. The byte is sent MSB first, and a 0 bit is sent as `sda_oe`=1.
- R8: `st_tx_ready` sets at the ninth rising SCL edge of each read byte, whether the controller answers ACK or NACK.
- R9: If the transmit holding register has not been written since its last load, the byte sent is 0xFF.
- R10: A NACK from the controller on a read byte sets `st_nack`. The block then keeps SDA released until the next START.
- R11: A `host_rd_status` strobe clears `st_end`, `st_nack` and `st_overrun`. A flag that is being set in the same cycle stays set.
- R12: After reset, `sda_oe`, `st_active`, `st_end`, `st_rx_ready`, `st_nack` and `st_overrun` are 0, and `st_tx_ready` is 1.
- R13: A repeated START followed by a matching address keeps `st_active` set and updates `st_read` to the new R/W bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr | input | 7 | Own bus address |
| scl_in | input | 1 | SCL line level (asynchronous) |
| sda_in | input | 1 | SDA line level (asynchronous) |
| sda_oe | output | 1 | 1 pulls SDA low |
| host_wr_tx | input | 1 | Strobe: write transmit holding register |
| host_tx_data | input | 8 | Data for the transmit holding register |
| host_rd_rx | input | 1 | Strobe: host reads the receive holding register |
| rx_data | output | 8 | Receive holding register |
| host_rd_status | input | 1 | Strobe: host reads status (clears sticky flags) |
| st_active | output | 1 | Access to this target is in progress |
| st_read | output | 1 | Direction, 1 = controller reads (valid while st_active) |
| st_end | output | 1 | An access has ended |
| st_rx_ready | output | 1 | Receive holding register holds unread data |
| st_tx_ready | output | 1 | Transmit holding register can take the next byte |
| st_nack | output | 1 | Controller answered a read byte with NACK |
| st_overrun | output | 1 | A received byte overwrote unread data |

## Verification
The bench goes after the moments where flags change hands. It checks that a repeated START to a foreign address ends an access, since a design that only watched for STOP would leave `st_active` high. It checks that a repeated START to the own address keeps the access running, where a faulty design would raise a false end of access. It reads a byte from an empty transmit register, and a design that sent stale data instead of 0xFF would fail there. It also clocks one more bit after a controller NACK, so a design that kept driving would corrupt the line. Two writes without a host read must set the overrun flag. On every bus bit the bench compares the SDA pull-down, clock by clock during SCL high, with the level its model expects, so an acknowledge or data bit one clock early or late shows up at once.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = DATA_W - 1;
    localparam int CNT_W  = $clog2(DATA_W + 1);

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_WR_DATA,
        S_WR_ACK,
        S_RD_DATA,
        S_RD_ACK,
        S_SKIP
    } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_p;
    logic              sda_p;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= scl_in;
                    sda_ff <= sda_in;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[STAGES-2:0], scl_in};
                    sda_ff <= {sda_ff[STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_q;
            sda_p <= sda_q;
        end
    end

    assign scl_q    = scl_ff[STAGES-1];
    assign sda_q    = sda_ff[STAGES-1];
    assign scl_rise = scl_q & ~scl_p;
    assign scl_fall = ~scl_q & scl_p;
    assign start_ev = scl_q & scl_p & sda_p & ~sda_q;
    assign stop_ev  = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              sda_q,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              sda_oe,
    output logic              ev_match,
    output logic              ev_dir,
    output logic              ev_miss,
    output logic              ev_rx,
    output logic [DATA_W-1:0] rx_byte,
    output logic              ev_tx_load,
    output logic              ev_tx_ack,
    output logic              ev_mnack
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LAST_OUT = CNT_W'(DATA_W - 1);

    tgt_state_e        st, nx;
    logic [DATA_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic              seen_rise;
    logic              addr_hit;
    logic              rw_bit;

    assign addr_hit = (sh[DATA_W-1:1] == own_addr);
    assign rw_bit   = sh[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nx;
    end

    always_comb begin
        nx = st;
        unique case (st)
            S_IDLE:     nx = S_IDLE;
            S_ADDR:     if (scl_fall && cnt == FULL_CNT) nx = addr_hit ? S_ADDR_ACK : S_SKIP;
            S_ADDR_ACK: if (scl_fall && seen_rise) nx = rw_bit ? S_RD_DATA : S_WR_DATA;
            S_WR_DATA:  if (scl_fall && cnt == FULL_CNT) nx = S_WR_ACK;
            S_WR_ACK:   if (scl_fall && seen_rise) nx = S_WR_DATA;
            S_RD_DATA:  if (scl_fall && cnt == LAST_OUT) nx = S_RD_ACK;
            S_RD_ACK: begin
                if (scl_rise && sda_q)           nx = S_SKIP;
                else if (scl_fall && seen_rise)  nx = S_RD_DATA;
            end
            S_SKIP:     nx = S_SKIP;
            default:    nx = S_IDLE;
        endcase
        if (start_ev)     nx = S_ADDR;
        else if (stop_ev) nx = S_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh         <= '0;
            cnt        <= '0;
            seen_rise  <= 1'b0;
            sda_oe     <= 1'b0;
            ev_match   <= 1'b0;
            ev_dir     <= 1'b0;
            ev_miss    <= 1'b0;
            ev_rx      <= 1'b0;
            rx_byte    <= '0;
            ev_tx_load <= 1'b0;
            ev_tx_ack  <= 1'b0;
            ev_mnack   <= 1'b0;
        end else begin
            ev_match   <= 1'b0;
            ev_miss    <= 1'b0;
            ev_rx      <= 1'b0;
            ev_tx_load <= 1'b0;
            ev_tx_ack  <= 1'b0;
            ev_mnack   <= 1'b0;
            if (start_ev) begin
                cnt       <= '0;
                seen_rise <= 1'b0;
                sda_oe    <= 1'b0;
            end else if (stop_ev) begin
                sda_oe    <= 1'b0;
            end else begin
                unique case (st)
                    S_ADDR, S_WR_DATA: begin
                        if (scl_rise) begin
                            sh  <= {sh[DATA_W-2:0], sda_q};
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall && cnt == FULL_CNT) begin
                            seen_rise <= 1'b0;
                            if (st == S_WR_DATA) begin
                                sda_oe  <= 1'b1;
                                ev_rx   <= 1'b1;
                                rx_byte <= sh;
                            end else if (addr_hit) begin
                                sda_oe   <= 1'b1;
                                ev_match <= 1'b1;
                                ev_dir   <= rw_bit;
                            end else begin
                                ev_miss  <= 1'b1;
                            end
                        end
                    end
                    S_ADDR_ACK, S_WR_ACK: begin
                        if (scl_rise) begin
                            seen_rise <= 1'b1;
                        end else if (scl_fall && seen_rise) begin
                            seen_rise <= 1'b0;
                            cnt       <= '0;
                            if (st == S_ADDR_ACK && rw_bit) begin
                                sh         <= tx_byte;
                                sda_oe     <= ~tx_byte[DATA_W-1];
                                ev_tx_load <= 1'b1;
                            end else begin
                                sda_oe     <= 1'b0;
                            end
                        end
                    end
                    S_RD_DATA: begin
                        if (scl_fall) begin
                            cnt <= cnt + 1'b1;
                            if (cnt == LAST_OUT) begin
                                sda_oe    <= 1'b0;
                                seen_rise <= 1'b0;
                            end else begin
                                sh     <= {sh[DATA_W-2:0], 1'b0};
                                sda_oe <= ~sh[DATA_W-2];
                            end
                        end
                    end
                    S_RD_ACK: begin
                        if (scl_rise) begin
                            seen_rise <= 1'b1;
                            ev_tx_ack <= 1'b1;
                            ev_mnack  <= sda_q;
                        end else if (scl_fall && seen_rise) begin
                            seen_rise  <= 1'b0;
                            cnt        <= '0;
                            sh         <= tx_byte;
                            sda_oe     <= ~tx_byte[DATA_W-1];
                            ev_tx_load <= 1'b1;
                        end
                    end
                    S_IDLE, S_SKIP: sda_oe <= 1'b0;
                    default:        sda_oe <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_tgt_hostregs.sv
module i2c_tgt_hostregs
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_match,
    input  logic              ev_dir,
    input  logic              ev_miss,
    input  logic              stop_ev,
    input  logic              ev_rx,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              ev_tx_load,
    input  logic              ev_tx_ack,
    input  logic              ev_mnack,
    input  logic              host_wr_tx,
    input  logic [DATA_W-1:0] host_tx_data,
    input  logic              host_rd_rx,
    input  logic              host_rd_status,
    output logic [DATA_W-1:0] rx_data,
    output logic [DATA_W-1:0] tx_byte,
    output logic              st_active,
    output logic              st_read,
    output logic              st_end,
    output logic              st_rx_ready,
    output logic              st_tx_ready,
    output logic              st_nack,
    output logic              st_overrun
);
    logic [DATA_W-1:0] tx_hold;
    logic              tx_valid;

    assign tx_byte = tx_valid ? tx_hold : '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_active   <= 1'b0;
            st_read     <= 1'b0;
            st_end      <= 1'b0;
            st_rx_ready <= 1'b0;
            st_tx_ready <= 1'b1;
            st_nack     <= 1'b0;
            st_overrun  <= 1'b0;
            rx_data     <= '0;
            tx_hold     <= '0;
            tx_valid    <= 1'b0;
        end else begin
            if (host_rd_status) begin
                st_end     <= 1'b0;
                st_nack    <= 1'b0;
                st_overrun <= 1'b0;
            end

            if (ev_match) begin
                st_active <= 1'b1;
                st_read   <= ev_dir;
            end else if (ev_miss || stop_ev) begin
                st_active <= 1'b0;
                if (st_active) st_end <= 1'b1;
            end

            if (ev_rx) begin
                rx_data     <= rx_byte;
                st_rx_ready <= 1'b1;
                if (st_rx_ready && !host_rd_rx) st_overrun <= 1'b1;
            end else if (host_rd_rx) begin
                st_rx_ready <= 1'b0;
            end

            if (ev_tx_load) begin
                tx_valid    <= 1'b0;
                st_tx_ready <= 1'b0;
            end else if (ev_tx_ack) begin
                st_tx_ready <= 1'b1;
            end
            if (host_wr_tx) begin
                tx_hold  <= host_tx_data;
                tx_valid <= 1'b1;
            end

            if (ev_mnack) st_nack <= 1'b1;
        end
    end
endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic              host_wr_tx,
    input  logic [DATA_W-1:0] host_tx_data,
    input  logic              host_rd_rx,
    output logic [DATA_W-1:0] rx_data,
    input  logic              host_rd_status,
    output logic              st_active,
    output logic              st_read,
    output logic              st_end,
    output logic              st_rx_ready,
    output logic              st_tx_ready,
    output logic              st_nack,
    output logic              st_overrun
);
    logic              scl_q, sda_q, scl_rise, scl_fall, start_ev, stop_ev;
    logic              ev_match, ev_dir, ev_miss, ev_rx;
    logic              ev_tx_load, ev_tx_ack, ev_mnack;
    logic [DATA_W-1:0] rx_byte;
    logic [DATA_W-1:0] tx_byte;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_q    (scl_q),
        .sda_q    (sda_q),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2c_tgt_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .own_addr   (own_addr),
        .sda_q      (sda_q),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_ev   (start_ev),
        .stop_ev    (stop_ev),
        .tx_byte    (tx_byte),
        .sda_oe     (sda_oe),
        .ev_match   (ev_match),
        .ev_dir     (ev_dir),
        .ev_miss    (ev_miss),
        .ev_rx      (ev_rx),
        .rx_byte    (rx_byte),
        .ev_tx_load (ev_tx_load),
        .ev_tx_ack  (ev_tx_ack),
        .ev_mnack   (ev_mnack)
    );

    i2c_tgt_hostregs u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .ev_match       (ev_match),
        .ev_dir         (ev_dir),
        .ev_miss        (ev_miss),
        .stop_ev        (stop_ev),
        .ev_rx          (ev_rx),
        .rx_byte        (rx_byte),
        .ev_tx_load     (ev_tx_load),
        .ev_tx_ack      (ev_tx_ack),
        .ev_mnack       (ev_mnack),
        .host_wr_tx     (host_wr_tx),
        .host_tx_data   (host_tx_data),
        .host_rd_rx     (host_rd_rx),
        .host_rd_status (host_rd_status),
        .rx_data        (rx_data),
        .tx_byte        (tx_byte),
        .st_active      (st_active),
        .st_read        (st_read),
        .st_end         (st_end),
        .st_rx_ready    (st_rx_ready),
        .st_tx_ready    (st_tx_ready),
        .st_nack        (st_nack),
        .st_overrun     (st_overrun)
    );
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_q,
    input logic sda_oe,
    input logic stop_ev,
    input logic ev_rx,
    input logic ev_tx_load,
    input logic host_rd_rx,
    input logic st_active,
    input logic st_end,
    input logic st_rx_ready,
    input logic st_overrun,
    input logic st_tx_ready,
    input logic st_nack
);
    AST_PULL_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_oe) |-> !scl_q); // R1
    AST_END_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n) $fell(st_active) |-> st_end); // R3
    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n) stop_ev |=> !st_active); // R4
    AST_RXRDY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (host_rd_rx && !ev_rx) |=> !st_rx_ready); // R5
    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n) (ev_rx && st_rx_ready && !host_rd_rx) |=> st_overrun); // R6
    AST_TXRDY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n) ev_tx_load |=> !st_tx_ready); // R7
    AST_NACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) $rose(st_nack) |-> !sda_oe); // R10
endmodule

bind i2c_target_ctrl i2c_tgt_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_q       (scl_q),
    .sda_oe      (sda_oe),
    .stop_ev     (stop_ev),
    .ev_rx       (ev_rx),
    .ev_tx_load  (ev_tx_load),
    .host_rd_rx  (host_rd_rx),
    .st_active   (st_active),
    .st_end      (st_end),
    .st_rx_ready (st_rx_ready),
    .st_overrun  (st_overrun),
    .st_tx_ready (st_tx_ready),
    .st_nack     (st_nack)
);

// File: tb/sim_i2c_target_ctrl.sv
`timescale 1ns/1ps
module sim_i2c_target_ctrl;
    localparam int H = 16;
    localparam logic [6:0] OWN = 7'h2A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       host_wr_tx = 1'b0;
    logic [7:0] host_tx_data = 8'h00;
    logic       host_rd_rx = 1'b0;
    logic       host_rd_status = 1'b0;
    logic       sda_oe, st_active, st_read, st_end, st_rx_ready;
    logic       st_tx_ready, st_nack, st_overrun;
    logic [7:0] rx_data;
    logic       sda_line;

    int checks = 0;
    int errors = 0;

    // reference model state
    bit       m_active, m_dir, m_end, m_rxr, m_ovr, m_txr, m_nack;
    bit [7:0] m_rx;
    bit       m_txv;
    bit [7:0] m_txh;
    bit       exp_oe, win, win_bad;
    bit [7:0] cur_tag;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_target_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .own_addr(OWN),
        .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
        .host_wr_tx(host_wr_tx), .host_tx_data(host_tx_data),
        .host_rd_rx(host_rd_rx), .rx_data(rx_data),
        .host_rd_status(host_rd_status),
        .st_active(st_active), .st_read(st_read), .st_end(st_end),
        .st_rx_ready(st_rx_ready), .st_tx_ready(st_tx_ready),
        .st_nack(st_nack), .st_overrun(st_overrun)
    );

    // per-clock comparison of the pull-down against the model while SCL is high
    always @(negedge clk) begin
        if (win && (sda_oe !== exp_oe)) win_bad = 1'b1;
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic win_open(input bit e);
        exp_oe = e;
        win_bad = 1'b0;
        win = 1'b1;
    endtask

    task automatic win_close(input string tag);
        win = 1'b0;
        checks++;
        if (win_bad) begin
            errors++;
            $display("FAIL %s sda_oe during SCL high actual=%0b expected=%0b", tag, ~exp_oe, exp_oe);
        end
    endtask

    task automatic status(input string tag);
        chk({tag, " active"}, {7'd0, st_active}, {7'd0, m_active});
        if (m_active) chk({tag, " dir"}, {7'd0, st_read}, {7'd0, m_dir});
        chk({tag, " end"}, {7'd0, st_end}, {7'd0, m_end});
        chk({tag, " rxr"}, {7'd0, st_rx_ready}, {7'd0, m_rxr});
        chk({tag, " txr"}, {7'd0, st_tx_ready}, {7'd0, m_txr});
        chk({tag, " nack"}, {7'd0, st_nack}, {7'd0, m_nack});
        chk({tag, " ovr"}, {7'd0, st_overrun}, {7'd0, m_ovr});
    endtask

    task automatic strobe_status();
        host_rd_status = 1'b1; wclk(1); host_rd_status = 1'b0;
        m_end = 0; m_nack = 0; m_ovr = 0;
        wclk(1);
    endtask

    task automatic strobe_rx();
        host_rd_rx = 1'b1; wclk(1); host_rd_rx = 1'b0;
        m_rxr = 0;
        wclk(1);
    endtask

    task automatic write_tx(input logic [7:0] d);
        host_tx_data = d; host_wr_tx = 1'b1; wclk(1); host_wr_tx = 1'b0;
        m_txv = 1; m_txh = d;
        wclk(1);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wclk(H);
        scl_m = 1'b1; wclk(H);
        sda_m = 1'b0; wclk(H);
        scl_m = 1'b0; wclk(H/2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wclk(H/2);
        scl_m = 1'b1; wclk(H);
        sda_m = 1'b1; wclk(H);
        if (m_active) m_end = 1;
        m_active = 0;
    endtask

    task automatic put_bit(input bit b, output bit txr_probe);
        sda_m = b; wclk(H/2);
        scl_m = 1'b1; win_open(1'b0);
        wclk(H/2); txr_probe = st_tx_ready; wclk(H/2);
        win_close("R1 master bit");
        scl_m = 1'b0; wclk(H/2);
    endtask

    task automatic get_bit(input bit e_oe, output bit b);
        sda_m = 1'b1; wclk(H/2);
        scl_m = 1'b1; win_open(e_oe);
        wclk(H/2); b = sda_line; wclk(H/2);
        win_close("R1 target bit");
        scl_m = 1'b0; wclk(H/2);
    endtask

    task automatic send_byte(input logic [7:0] d, input bit exp_ack, input string tag);
        bit p, b;
        for (int i = 7; i >= 0; i--) put_bit(d[i], p);
        get_bit(exp_ack, b);
        chk({tag, " ack"}, {7'd0, ~b}, {7'd0, exp_ack});
    endtask

    task automatic recv_byte(input bit master_ack, input string tag);
        bit p, b;
        logic [7:0] got, exp;
        exp = m_txv ? m_txh : 8'hFF;
        m_txv = 0;
        for (int i = 7; i >= 0; i--) begin
            get_bit(~exp[i], b);
            got[i] = b;
        end
        chk({tag, " data"}, got, exp);
        put_bit(~master_ack, p);
        chk({tag, " R8 txr after ack slot"}, {7'd0, p}, 8'd1);
    endtask

    initial begin
        bit b;
        win = 0; win_bad = 0; exp_oe = 0;
        m_active = 0; m_dir = 0; m_end = 0; m_rxr = 0; m_ovr = 0;
        m_txr = 1; m_nack = 0; m_rx = 0; m_txv = 0; m_txh = 0;
        wclk(4);
        rst_n = 1'b1;
        wclk(4);
        // R12: reset state
        status("R12 reset");
        chk("R12 sda_oe", {7'd0, sda_oe}, 8'd0);

        // R3: foreign address, no ack, following byte ignored
        bus_start();
        send_byte({7'h15, 1'b0}, 1'b0, "R3 foreign addr");
        send_byte(8'h00, 1'b0, "R3 skip byte");
        status("R3 after foreign");
        bus_stop();
        wclk(4);
        status("R4 stop without access");

        // R2, R5, R6: write access
        bus_start();
        send_byte({OWN, 1'b0}, 1'b1, "R2 own write addr");
        m_active = 1; m_dir = 0;
        status("R2 write access");
        send_byte(8'h5A, 1'b1, "R5 byte1");
        m_rxr = 1; m_rx = 8'h5A;
        status("R5 after byte1");
        chk("R5 rx_data", rx_data, m_rx);
        strobe_rx();
        status("R5 after host read");
        send_byte(8'h81, 1'b1, "R6 byte2");
        m_rxr = 1;
        send_byte(8'h7E, 1'b1, "R6 byte3");
        m_ovr = 1; m_rx = 8'h7E;
        status("R6 overrun");
        chk("R6 rx_data overwritten", rx_data, m_rx);
        strobe_rx();
        bus_stop();
        wclk(4);
        status("R4 stop ends access");
        strobe_status();
        status("R11 status read clears");

        // R7, R8, R9, R10: read access
        write_tx(8'hA5);
        bus_start();
        send_byte({OWN, 1'b1}, 1'b1, "R2 own read addr");
        m_active = 1; m_dir = 1; m_txr = 0;
        status("R7 load at ack end");
        recv_byte(1'b1, "R7 byte A5");
        m_txr = 0;
        status("R9 next load");
        recv_byte(1'b0, "R9 empty gives FF");
        m_txr = 1; m_nack = 1;
        wclk(2);
        status("R10 nack seen");
        get_bit(1'b0, b);
        chk("R10 released after nack", {7'd0, b}, 8'd1);

        // R13: repeated start to own address, now writing
        bus_start();
        send_byte({OWN, 1'b0}, 1'b1, "R13 restart own");
        m_dir = 0;
        status("R13 still active");
        chk("R13 no end", {7'd0, st_end}, 8'd0);
        send_byte(8'h33, 1'b1, "R5 byte after restart");
        m_rxr = 1; m_rx = 8'h33;
        chk("R5 rx_data 33", rx_data, 8'h33);

        // R3: repeated start to a foreign address ends access
        bus_start();
        send_byte({7'h10, 1'b0}, 1'b0, "R3 restart foreign");
        m_active = 0; m_end = 1;
        wclk(2);
        status("R3 access ended");
        bus_stop();
        wclk(4);
        strobe_rx();
        strobe_status();
        status("R11 final clear");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule